// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, frame clock and serial data) into parallel left and right samples. It understands four framing styles: left-justified, I2S, right-justified and a DSP style in which a short frame-clock pulse introduces each channel. Word lengths of 16, 18 and 20 bits are supported. A 16-bit stream packed into 32 bit clocks per stereo frame is also accepted. The bit clock may stop between bits or between bursts. The frame clock must keep running.

Format and word length are taken from two select inputs while reset is held, and they stay fixed until the next reset. Serial capture runs on the bit clock. Each finished stereo pair is handed to the system clock domain through a toggle synchronizer. It appears there on `out_left` and `out_right` with a one-cycle `out_valid` strobe. Samples are MSB-aligned in a 20-bit field, and the unused low bits are zero.

Top module: `serial_audio_rx`

## Requirements
- R1: A pair is emitted only after a left word and then a right word have both completed. A slot that was already in progress when the receiver left reset yields no output, and each sent frame yields exactly one pair.
- R2: With `fmt_sel`=0 (left-justified), frame clock high marks the left channel. The MSB is the bit captured on the first rising bit-clock edge after the frame-clock transition.
- R3: With `fmt_sel`=1 (I2S), frame clock low marks the left channel. The MSB is captured one bit after the frame-clock transition, and the bit at the transition is ignored.
- R4: With `fmt_sel`=2 (right-justified), frame clock high marks the left channel. The word is made of the last N bits captured on rising edges before the next frame-clock transition, whatever bits came earlier in the slot.
- R5: With `fmt_sel`=3 (DSP pulse), capture happens on the falling bit-clock edge. A frame clock seen high after being low starts a slot, and the MSB follows on the next capture edge. The first pulse after reset is the left channel, and the channels then alternate.
- R6: `wlen_sel` selects N: 0 gives 16 bits, 1 gives 18 bits, and 2 or 3 give 20 bits. Slot bits beyond N are ignored. The word is placed with its MSB at output bit 19, and the remaining low bits are zero.
- R7: In left-justified and right-justified modes, a 16-bit stream at 32 bit clocks per frame is decoded correctly.
- R8: Pauses of any length in the bit clock between bits do not change the decoded words.
- R9: `fmt_sel` and `wlen_sel` are sampled only while `rst` is high. Changing them afterwards has no effect.
- R10: `out_valid` is high for exactly one `clk` cycle per pair. `out_left` and `out_right` hold their values until the next strobe.
- R11: While `rst` is high, `out_valid`, `out_left` and `out_right` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 DSP pulse |
| wlen_sel | input | 2 | Word length: 0 = 16, 1 = 18, 2/3 = 20 bits |
| bclk_in | input | 1 | Serial bit clock, may be gated |
| lrclk_in | input | 1 | Frame (left/right) clock |
| sdata_in | input | 1 | Serial data, MSB first, two's complement |
| out_left | output | 20 | Left sample, MSB-aligned, zero fill |
| out_right | output | 20 | Right sample, MSB-aligned, zero fill |
| out_valid | output | 1 | One-cycle strobe per stereo pair |

## Verification
The assertions check three things on every cycle. The strobe is a single cycle wide, the outputs hold still between strobes, and the low bits below a short word stay zero. In the serial domain, a pair is only released once a left word is pending. Only the bench scenarios can show that each framing style finds the right MSB and the right channel polarity. The same goes for right-justified words that are taken from the tail of a slot, for packed frames and for a gated bit clock. They also show that configuration changes after reset are ignored and that a partial slot at start-up is discarded. The scoreboard compares every emitted pair against words the bench computed itself.

// File: rtl/audrx_pkg.sv
package audrx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  localparam int WL_SHORT = 16;
  localparam int WL_MID   = 18;
  localparam int WL_LONG  = 20;
endpackage

// File: rtl/audrx_slot.sv
module audrx_slot
  import audrx_pkg::*;
#(
  parameter int MAXW = 20,
  parameter int CW   = 7
) (
  input  logic            cap_clk,
  input  logic            srst,
  input  fmt_e            fmt,
  input  logic [CW-1:0]   wbits,
  input  logic            lr,
  input  logic            sd,
  output logic [MAXW-1:0] pair_l,
  output logic [MAXW-1:0] pair_r,
  output logic            pair_tgl
);
  logic            seen, armed, lr_q, ch_q, have_left;
  logic [CW-1:0]   cnt;
  logic [MAXW-1:0] sr, left_hold;

  logic            is_dsp, is_rj, edge_hit, take, ended_left;
  logic [CW-1:0]   off, idx, pad;
  logic [MAXW-1:0] base, sr_next, aligned;

  always_comb begin
    is_dsp   = (fmt == FMT_DSP);
    is_rj    = (fmt == FMT_RJ);
    edge_hit = seen && (is_dsp ? (lr && !lr_q) : (lr != lr_q));
    off      = (fmt == FMT_I2S || is_dsp) ? CW'(1) : CW'(0);
    idx      = edge_hit ? '0 : cnt;
    take     = is_rj || ((idx >= off) && (idx < off + wbits));
    // level of the slot that just ended decides its channel
    ended_left = is_dsp ? !ch_q : (lr_q == (fmt != FMT_I2S));
    base     = edge_hit ? '0 : sr;
    sr_next  = take ? {base[MAXW-2:0], sd} : base;
    pad      = CW'(MAXW) - wbits;
    aligned  = sr << pad;
  end

  always_ff @(posedge cap_clk) begin
    if (srst) begin
      seen      <= 1'b0;
      armed     <= 1'b0;
      lr_q      <= 1'b0;
      ch_q      <= 1'b1;
      have_left <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      left_hold <= '0;
      pair_l    <= '0;
      pair_r    <= '0;
      pair_tgl  <= 1'b0;
    end else begin
      seen <= 1'b1;
      lr_q <= lr;
      sr   <= sr_next;
      if (edge_hit) cnt <= CW'(1);
      else if (cnt != '1) cnt <= cnt + 1'b1;
      if (edge_hit) begin
        armed <= 1'b1;
        ch_q  <= ~ch_q;
        if (armed) begin
          if (ended_left) begin
            left_hold <= aligned;
            have_left <= 1'b1;
          end else if (have_left) begin
            pair_l    <= left_hold;
            pair_r    <= aligned;
            pair_tgl  <= ~pair_tgl;
            have_left <= 1'b0;
          end
        end
      end
    end
  end

  // R1: a pair leaves only when a left word was waiting
  assert_pair_after_left_R1: assert property (@(posedge cap_clk) disable iff (srst)
    (pair_tgl != $past(pair_tgl)) |-> $past(have_left));
endmodule

// File: rtl/audrx_xfer.sv
module audrx_xfer #(
  parameter int MAXW  = 20,
  parameter int SYNCN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pair_tgl,
  input  logic [MAXW-1:0] pair_l,
  input  logic [MAXW-1:0] pair_r,
  output logic [MAXW-1:0] out_left,
  output logic [MAXW-1:0] out_right,
  output logic            out_valid
);
  logic [SYNCN-1:0] ts;
  logic             fire;

  assign fire = ts[SYNCN-1] ^ ts[SYNCN-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ts        <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      ts        <= {ts[SYNCN-2:0], pair_tgl};
      out_valid <= fire;
      if (fire) begin
        out_left  <= pair_l;
        out_right <= pair_r;
      end
    end
  end

  // R10: strobe is one cycle wide
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R10: outputs only move together with the strobe
  assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import audrx_pkg::*;
#(
  parameter int MAXW = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      fmt_sel,
  input  logic [1:0]      wlen_sel,
  input  logic            bclk_in,
  input  logic            lrclk_in,
  input  logic            sdata_in,
  output logic [MAXW-1:0] out_left,
  output logic [MAXW-1:0] out_right,
  output logic            out_valid
);
  localparam int CW = $clog2(2 * MAXW + 1) + 1;

  logic [1:0]      cfg_fmt, cfg_wl;
  logic [CW-1:0]   wbits;
  logic            cap_clk;
  logic [1:0]      rs;
  logic [MAXW-1:0] pair_l, pair_r;
  logic            pair_tgl;

  // configuration is only captured while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_fmt <= fmt_sel;
      cfg_wl  <= wlen_sel;
    end
  end

  always_comb begin
    case (cfg_wl)
      2'd0:    wbits = CW'(WL_SHORT);
      2'd1:    wbits = CW'(WL_MID);
      default: wbits = CW'(WL_LONG);
    endcase
  end

  // DSP framing captures on the falling bit-clock edge
  assign cap_clk = bclk_in ^ (cfg_fmt == FMT_DSP);

  always_ff @(posedge cap_clk) rs <= {rs[0], rst};

  audrx_slot #(.MAXW(MAXW), .CW(CW)) u_slot (
    .cap_clk  (cap_clk),
    .srst     (rs[1]),
    .fmt      (fmt_e'(cfg_fmt)),
    .wbits    (wbits),
    .lr       (lrclk_in),
    .sd       (sdata_in),
    .pair_l   (pair_l),
    .pair_r   (pair_r),
    .pair_tgl (pair_tgl)
  );

  audrx_xfer #(.MAXW(MAXW)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .pair_tgl  (pair_tgl),
    .pair_l    (pair_l),
    .pair_r    (pair_r),
    .out_left  (out_left),
    .out_right (out_right),
    .out_valid (out_valid)
  );

  // R6: zero fill below a 16-bit word
  assert_fill16_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_wl == 2'd0) |-> (out_left[MAXW-17:0] == '0 && out_right[MAXW-17:0] == '0));
  // R6: zero fill below an 18-bit word
  assert_fill18_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_wl == 2'd1) |-> (out_left[MAXW-19:0] == '0 && out_right[MAXW-19:0] == '0));
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'd0, wlen_sel = 2'd0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [19:0] out_left, out_right;
  logic        out_valid;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .bclk_in(bclk), .lrclk_in(lrclk), .sdata_in(sdata),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
  );

  int total = 0, bad = 0, gap = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] align(input logic [19:0] w, input int wl);
    logic [19:0] m;
    m = w & ((20'h1 << wl) - 20'h1);
    return m << (20 - wl);
  endfunction

  function automatic logic [19:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[27:8];
  endfunction

  task automatic bit_cycle(input logic lv, input logic d, input bit dsp);
    lrclk = lv;
    sdata = d;
    repeat (4 + gap) @(negedge clk);
    bclk = dsp ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    bclk = dsp ? 1'b1 : 1'b0;
  endtask

  task automatic send_slot(input int fmt, input int wl, input int slot, input bit left, input logic [19:0] w);
    for (int i = 0; i < slot; i++) begin
      logic lv, d;
      case (fmt)
        0: begin lv = left;        d = (i < wl) ? w[wl-1-i] : 1'b1; end
        1: begin lv = !left;       d = (i >= 1 && i <= wl) ? w[wl-i] : 1'b1; end
        2: begin lv = left;        d = (i >= slot - wl) ? w[slot-1-i] : 1'b1; end
        default: begin lv = (i == 0); d = (i >= 1 && i <= wl) ? w[wl-i] : 1'b1; end
      endcase
      bit_cycle(lv, d, fmt == 3);
    end
  endtask

  task automatic send_frame(input int fmt, input int wl, input int slot, input string tag);
    logic [19:0] l, r;
    l = next_word();
    r = next_word();
    exp_q.push_back({align(l, wl), align(r, wl)});
    tag_q.push_back(tag);
    send_slot(fmt, wl, slot, 1'b1, l);
    send_slot(fmt, wl, slot, 1'b0, r);
  endtask

  task automatic close_run(input int fmt);
    if (fmt == 3) begin
      bit_cycle(1'b1, 1'b0, 1'b1);
      repeat (3) bit_cycle(1'b0, 1'b0, 1'b1);
    end else begin
      repeat (4) bit_cycle(fmt == 1 ? 1'b0 : 1'b1, 1'b0, 1'b0);
    end
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R1 every sent frame delivered", 40'(exp_q.size()), 40'd0);
  endtask

  task automatic do_reset(input int fmt, input int wl, input logic idle_lv);
    @(negedge clk);
    rst = 1'b1;
    fmt_sel = 2'(fmt);
    wlen_sel = 2'(wl);
    bclk = (fmt == 3);
    lrclk = idle_lv;
    exp_q.delete();
    tag_q.delete();
    repeat (2) @(negedge clk);
    repeat (6) bit_cycle(idle_lv, 1'b0, fmt == 3);
    check(out_valid == 1'b0 && out_left == 20'd0 && out_right == 20'd0, "R11 reset state",
          {out_left, out_right}, 40'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) bit_cycle(idle_lv, 1'b0, fmt == 3);
  endtask

  // scoreboard monitor
  bit          hold_chk = 0;
  logic [39:0] held;
  always @(negedge clk) begin
    if (hold_chk) begin
      hold_chk = 0;
      check(!out_valid && {out_left, out_right} == held, "R10 strobe width and hold",
            {out_left, out_right}, held);
    end
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected pair", {out_left, out_right}, 40'd0);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_left, out_right} == e, t, {out_left, out_right}, e);
      end
      held = {out_left, out_right};
      hold_chk = 1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: partial left slot at start-up must be dropped
    do_reset(0, 0, 1'b1);
    repeat (8) bit_cycle(1'b0, 1'b1, 1'b0);
    send_frame(0, 16, 32, "R1 R2 LJ16 after partial slot");
    send_frame(0, 16, 32, "R2 R6 LJ16");
    close_run(0);

    do_reset(0, 2, 1'b0);
    send_frame(0, 20, 32, "R2 LJ20");
    send_frame(0, 20, 32, "R2 LJ20");
    close_run(0);

    do_reset(0, 1, 1'b0);
    send_frame(0, 18, 32, "R6 LJ18 tail ignored");
    close_run(0);

    do_reset(1, 1, 1'b1);
    send_frame(1, 18, 32, "R3 I2S18");
    send_frame(1, 18, 32, "R3 I2S18");
    close_run(1);

    do_reset(2, 0, 1'b0);
    send_frame(2, 16, 32, "R4 RJ16 64 per frame");
    send_frame(2, 16, 32, "R4 RJ16 64 per frame");
    close_run(2);

    do_reset(2, 3, 1'b0);
    send_frame(2, 20, 32, "R4 R6 RJ20 select 3");
    close_run(2);

    do_reset(0, 0, 1'b0);
    send_frame(0, 16, 16, "R7 packed LJ");
    send_frame(0, 16, 16, "R7 packed LJ");
    close_run(0);

    do_reset(2, 0, 1'b0);
    send_frame(2, 16, 16, "R7 packed RJ");
    send_frame(2, 16, 16, "R7 packed RJ");
    close_run(2);

    do_reset(3, 0, 1'b0);
    send_frame(3, 16, 24, "R5 DSP16");
    send_frame(3, 16, 24, "R5 DSP16");
    close_run(3);

    do_reset(3, 2, 1'b0);
    send_frame(3, 20, 22, "R5 DSP20");
    close_run(3);

    do_reset(0, 2, 1'b0);
    gap = 9;
    send_frame(0, 20, 32, "R8 gated bit clock");
    send_frame(0, 20, 32, "R8 gated bit clock");
    close_run(0);
    gap = 0;

    // R9: selects change after reset and must be ignored
    do_reset(0, 0, 1'b0);
    fmt_sel = 2'd3;
    wlen_sel = 2'd2;
    send_frame(0, 16, 32, "R9 config held");
    send_frame(0, 16, 32, "R9 config held");
    close_run(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule